// File: doc/BRIEF.md
# Tri-State Phase Frequency Detector with Lock Indicator

The block compares two pulse streams that have already been brought into a fast sampling clock: a reference stream from the reference divider and a feedback stream from the loop divider. A rising edge on the reference sets an "up" flag, and a rising edge on the feedback sets a "down" flag. When both flags are set, a delayed common clear drops them together. The time that each flag stays high therefore grows with the phase error between the streams, and also with their frequency error. The two flags drive the pump request outputs, which are meant for a charge pump outside the block.

A polarity input swaps the two pump outputs, which suits loops whose oscillator gain is negative. A quiet input forces both pump outputs low while the comparison carries on inside the block. The reset delay is fixed at `RST_DLY` fast-clock cycles. It sets a minimum pulse on both outputs even when the phase error is zero, so the detector has no dead zone.

A digital lock monitor measures each comparison cycle. It counts the cycles in which either flag is high, from the first set to the common clear. After `LOCK_CNT` consecutive comparisons no wider than `WIDTH_MAX`, the lock indicator goes high. It then stays high except for narrow low pulses while a comparison is in progress. A single wide comparison drops the lock.

Top module: `phase_lock_detector`

## Requirements
- R1: A 0-to-1 transition of `ref_in` between two clock edges sets the up flag. Holding `ref_in` high for several cycles counts as one transition, and further reference transitions while the flag is set have no effect on the pulse width.
- R2: A 0-to-1 transition of `fb_in` sets the down flag under the same rules, including the single count for a held-high input.
- R3: Once both flags are high, they stay high together for exactly `RST_DLY` cycles and are then cleared on the same edge. Coincident edges therefore give a pulse of `RST_DLY` cycles on both outputs.
- R4: With `invert_pol`=0, if the reference edge leads by e cycles, `pump_up` is high for e+`RST_DLY` cycles and `pump_dn` for `RST_DLY` cycles. If the feedback edge leads by e cycles, the widths are the other way round.
- R5: With `invert_pol`=1, the widths in R4 swap between `pump_up` and `pump_dn`.
- R6: With `quiet`=1, both pump outputs stay 0. The comparison and the lock monitor keep working unchanged.
- R7: The comparison width is the number of cycles in which either flag is high up to the clear. The lock indicator rises once `LOCK_CNT` consecutive comparisons have a width of at most `WIDTH_MAX`.
- R8: A comparison wider than `WIDTH_MAX` clears the lock at its clearing edge and restarts the consecutive count from zero.
- R9: `lock_ind` is 0 in every cycle in which either flag is high. In all other cycles it equals the lock state.
- R10: While `rst_n`=0, and directly after reset, `pump_up`, `pump_dn` and `lock_ind` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference divider output, synchronous to clk |
| fb_in | input | 1 | Feedback divider output, synchronous to clk |
| invert_pol | input | 1 | 1 swaps the pump outputs |
| quiet | input | 1 | 1 forces both pump outputs low |
| pump_up | output | 1 | Charge-up request |
| pump_dn | output | 1 | Charge-down request |
| lock_ind | output | 1 | Lock indicator, high when locked with low pulses during comparisons |

## Verification
An input edge sampled at clock edge t shows up on its pump output after edge t: one edge-detect stage and one flag register lie on the path. The clear lands on the `RST_DLY`-th overlapping edge, and the lock state changes on that same clearing edge. The bench therefore drives inputs and samples outputs only at falling edges, and counts pump-high samples across a 24-cycle window for each comparison. It compares the lock indicator only at the end of the window, by which time every comparison in the sweep has cleared. It also counts, sample by sample, any cycle in which `lock_ind` is high while a pump output is high.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_pair_t;

    typedef enum logic {
        POL_NORMAL  = 1'b0,
        POL_SWAPPED = 1'b1
    } pump_pol_e;

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_in;
    end

    assign rise_o = sig_in & ~st_q.prev;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pfd_flops.sv
module pfd_flops #(
    parameter int RST_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic up_o,
    output logic dn_o,
    output logic clr_o
);
    localparam int DLY_W = (RST_DLY < 1) ? 1 : $clog2(RST_DLY + 1);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(RST_DLY - 1);

    typedef struct packed {
        logic             up;
        logic             dn;
        logic [DLY_W-1:0] dly;
    } flop_st_t;

    flop_st_t st_d, st_q;
    logic     both;
    logic     clr;

    always_comb begin
        st_d = st_q;
        both = st_q.up & st_q.dn;
        clr  = both && (st_q.dly == DLY_LAST);
        if (clr) begin
            st_d.up  = 1'b0;
            st_d.dn  = 1'b0;
            st_d.dly = '0;
        end else begin
            st_d.up  = st_q.up | ref_rise;
            st_d.dn  = st_q.dn | fb_rise;
            st_d.dly = both ? st_q.dly + 1'b1 : '0;
        end
    end

    assign up_o  = st_q.up;
    assign dn_o  = st_q.dn;
    assign clr_o = clr;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
    parameter int WIDTH_MAX = 4,
    parameter int LOCK_CNT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic clr,
    output logic lock_o
);
    localparam int WID_W = $clog2(WIDTH_MAX + 2);
    localparam int CNT_W = $clog2(LOCK_CNT + 1);
    localparam logic [WID_W-1:0] WID_SAT  = WID_W'(WIDTH_MAX + 1);
    localparam logic [WID_W-1:0] WID_LIM  = WID_W'(WIDTH_MAX);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LOCK_CNT);

    typedef struct packed {
        logic [WID_W-1:0] wid;
        logic [CNT_W-1:0] good;
        logic             lock;
    } lock_st_t;

    lock_st_t         st_d, st_q;
    logic [WID_W-1:0] wid_n;
    logic [CNT_W-1:0] good_n;

    always_comb begin
        st_d   = st_q;
        wid_n  = (active && st_q.wid != WID_SAT) ? st_q.wid + 1'b1 : st_q.wid;
        good_n = (st_q.good == CNT_FULL) ? st_q.good : st_q.good + 1'b1;
        if (clr) begin
            st_d.wid = '0;
            if (wid_n <= WID_LIM) begin
                st_d.good = good_n;
                st_d.lock = (good_n == CNT_FULL);
            end else begin
                st_d.good = '0;
                st_d.lock = 1'b0;
            end
        end else begin
            st_d.wid = wid_n;
        end
    end

    assign lock_o = st_q.lock;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector
    import pfd_pkg::*;
#(
    parameter int RST_DLY   = 2,
    parameter int WIDTH_MAX = 4,
    parameter int LOCK_CNT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic invert_pol,
    input  logic quiet,
    output logic pump_up,
    output logic pump_dn,
    output logic lock_ind
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_in;
    logic [NCH-1:0] rise;
    logic           up_q, dn_q, clr, lock_q;
    pump_pair_t     pair, pair_out;
    pump_pol_e      pol;

    assign raw_in = {fb_in, ref_in};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_edge
        pfd_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (raw_in[ch]),
            .rise_o (rise[ch])
        );
    end

    pfd_flops #(.RST_DLY(RST_DLY)) u_flops (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (rise[0]),
        .fb_rise  (rise[1]),
        .up_o     (up_q),
        .dn_o     (dn_q),
        .clr_o    (clr)
    );

    pfd_lock_mon #(.WIDTH_MAX(WIDTH_MAX), .LOCK_CNT(LOCK_CNT)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (up_q | dn_q),
        .clr    (clr),
        .lock_o (lock_q)
    );

    always_comb begin
        pol     = pump_pol_e'(invert_pol);
        pair.up = up_q;
        pair.dn = dn_q;
        if (quiet)                    pair_out = '0;
        else if (pol == POL_SWAPPED)  pair_out = '{up: pair.dn, dn: pair.up};
        else                          pair_out = pair;
    end

    assign pump_up  = pair_out.up;
    assign pump_dn  = pair_out.dn;
    assign lock_ind = lock_q & ~(up_q | dn_q);
endmodule

// File: rtl/phase_lock_detector_chk.sv
module phase_lock_detector_chk #(
    parameter int RST_DLY = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ref_in,
    input logic fb_in,
    input logic quiet,
    input logic pump_up,
    input logic pump_dn,
    input logic lock_ind,
    input logic up_q,
    input logic dn_q,
    input logic lock_q
);
    int ovl_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            ovl_q <= 0;
        else if (up_q && dn_q) ovl_q <= ovl_q + 1;
        else                   ovl_q <= 0;
    end

    assert_up_needs_ref_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_q) |-> $past(ref_in));

    assert_dn_needs_fb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_q) |-> $past(fb_in));

    assert_overlap_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && dn_q) |-> (ovl_q < RST_DLY));

    assert_common_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up_q) |-> $fell(dn_q));

    assert_quiet_pumps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> (!pump_up && !pump_dn));

    assert_lock_moves_at_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(up_q && dn_q));

    assert_lock_low_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ind |-> (!up_q && !dn_q && !pump_up && !pump_dn));
endmodule

bind phase_lock_detector phase_lock_detector_chk #(.RST_DLY(RST_DLY)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_in),
    .fb_in    (fb_in),
    .quiet    (quiet),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .lock_ind (lock_ind),
    .up_q     (up_q),
    .dn_q     (dn_q),
    .lock_q   (lock_q)
);

// File: tb/phase_lock_detector_bench.sv
module phase_lock_detector_bench;
    localparam int D    = 2;
    localparam int WMAX = 4;
    localparam int LCNT = 3;
    localparam int WIN  = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0, fb_in = 1'b0, invert_pol = 1'b0, quiet = 1'b0;
    logic pump_up, pump_dn, lock_ind;

    int checks = 0;
    int fails  = 0;
    int good_m = 0;
    bit lock_m = 1'b0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    phase_lock_detector #(.RST_DLY(D), .WIDTH_MAX(WMAX), .LOCK_CNT(LCNT)) u_phase_lock_detector (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .invert_pol(invert_pol), .quiet(quiet),
        .pump_up(pump_up), .pump_dn(pump_dn), .lock_ind(lock_ind)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One comparison: edges at given offsets, widths and lock checked over a window.
    task automatic run_cmp(input int ref_at, input int ref_len, input int ref2_at,
                           input int fb_at, input int fb_len, input bit pol,
                           input bit qt, input string tag);
        int up_cnt = 0, dn_cnt = 0, bad_lock = 0;
        int lead = fb_at - ref_at;
        int w_up = (lead >= 0) ? lead + D : D;
        int w_dn = (lead >= 0) ? D : D - lead;
        int width = (w_up > w_dn) ? w_up : w_dn;
        int exp_up = qt ? 0 : (pol ? w_dn : w_up);
        int exp_dn = qt ? 0 : (pol ? w_up : w_dn);
        for (int c = 0; c < WIN; c++) begin
            @(negedge clk);
            if (pump_up) up_cnt++;
            if (pump_dn) dn_cnt++;
            if (lock_ind && (pump_up || pump_dn)) bad_lock++;
            invert_pol = pol;
            quiet      = qt;
            ref_in = ((c >= ref_at) && (c < ref_at + ref_len)) || (c == ref2_at);
            fb_in  = (c >= fb_at) && (c < fb_at + fb_len);
        end
        if (width <= WMAX) begin
            good_m = (good_m < LCNT) ? good_m + 1 : good_m;
            lock_m = (good_m >= LCNT);
        end else begin
            good_m = 0;
            lock_m = 1'b0;
        end
        check({tag, " up width"}, up_cnt, exp_up);
        check({tag, " dn width"}, dn_cnt, exp_dn);
        check(lock_m ? "R7 lock state" : "R8 lock state", int'(lock_ind), int'(lock_m));
        check("R9 lock low during pulse", bad_lock, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R10 reset up", int'(pump_up), 0);
        check("R10 reset dn", int'(pump_dn), 0);
        check("R10 reset lock", int'(lock_ind), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 post-reset lock", int'(lock_ind), 0);

        // Lock acquisition and loss with known widths.
        run_cmp(2, 1, -1, 3, 1, 1'b0, 1'b0, "R4 lead1");
        run_cmp(2, 1, -1, 2, 1, 1'b0, 1'b0, "R3 zero");
        run_cmp(3, 1, -1, 2, 1, 1'b0, 1'b0, "R4 lag1");
        run_cmp(2, 1, -1, 6, 1, 1'b0, 1'b0, "R4 lead4");
        run_cmp(2, 1, -1, 2, 1, 1'b0, 1'b1, "R6 zero");

        // Sweep of phase error, polarity and quiet.
        for (int p = 0; p < 2; p++)
            for (int q = 0; q < 2; q++)
                for (int e = -6; e <= 6; e++) begin
                    string tg = (q != 0) ? "R6" : (p != 0) ? "R5" : (e == 0) ? "R3" : "R4";
                    run_cmp(e < 0 ? 2 - e : 2, 1, -1, e < 0 ? 2 : 2 + e, 1, p[0], q[0], tg);
                end

        // Held-high inputs and repeated edges.
        run_cmp(2, 4, -1, 4, 1, 1'b0, 1'b0, "R1 held ref");
        run_cmp(2, 1, 4, 6, 1, 1'b0, 1'b0, "R1 second ref");
        run_cmp(4, 1, -1, 2, 4, 1'b0, 1'b0, "R2 held fb");
        for (int k = 0; k < LCNT; k++)
            run_cmp(2, 1, -1, 3, 1, 1'b1, 1'b0, "R7 relock");
        run_cmp(2, 1, -1, 7, 1, 1'b0, 1'b0, "R8 wide");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule